// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Function Decoder

This block is the combinational compute stage of a simple processor datapath. It takes two operands, a 2-bit operation class from the main controller and the 6-bit function field of the current instruction. From these it produces a result, a zero flag and the 4-bit operation select it decoded on the way.

The decode has two levels. The operation class chooses first: it either forces an addition (address and program-counter arithmetic), forces a subtraction (the equality test of a conditional branch), or hands the choice to the function field (register-register instructions). The unit then performs AND, OR, NOR, add, subtract or signed set-less-than.

The zero flag marks an all-zero result, which is what the branch decision looks at. The block holds no state, and the operand width is a parameter.

Top module: `alu_unit`

## Requirements
- R1: With operation class 2'b00 the select is add (4'b0010) and the result is A + B, whatever the function field holds.
- R2: With operation class 2'b01 the select is subtract (4'b0110) and the result is A - B, whatever the function field holds.
- R3: With operation class 2'b10 the function field picks the operation: 6'b100000 add (select 4'b0010), 6'b100010 subtract (4'b0110), 6'b100100 AND (4'b0000), 6'b100101 OR (4'b0001), 6'b100111 NOR (4'b1100), 6'b101010 set-less-than (4'b0111).
- R4: Operation class 2'b11, and any function code not listed in R3 under class 2'b10, selects add (4'b0010).
- R5: Add and subtract wrap modulo 2^WIDTH and raise no overflow indication.
- R6: Set-less-than gives 1 in bit 0 and zero in every other bit when A is less than B as signed numbers; otherwise it gives all zeros.
- R7: The zero output is 1 exactly when every bit of the result is 0.
- R8: AND, OR and NOR are computed bit by bit over the full width of the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_class_i | input | 2 | Operation class from the main controller |
| func_i | input | 6 | Function field of the instruction |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| op_sel_o | output | 4 | Decoded operation select |

## Verification
The bench builds the unit with the default WIDTH of 32. At that width it can drive the signed extremes 32'h8000_0000 and 32'h7FFF_FFFF, which are the cases where set-less-than must use the operand signs rather than the sign of the difference. The same width puts the wrap of 32'hFFFF_FFFF + 1 and 0 - 1 within reach. Every one of the 64 function codes is swept under each operation class, so the decode default and the ignored function field are both covered.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FUNC_W = 6;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FUNC = 2'b10,
        CLS_RSVD = 2'b11
    } op_class_e;

    localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNC_W-1:0] FN_NOR = 6'b100111;
    localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;

    // Second decode level: function field to operation; unknown codes add.
    function automatic alu_op_e func_to_op(input logic [FUNC_W-1:0] fn);
        alu_op_e op;
        case (fn)
            FN_SUB:  op = OP_SUB;
            FN_AND:  op = OP_AND;
            FN_OR:   op = OP_OR;
            FN_NOR:  op = OP_NOR;
            FN_SLT:  op = OP_SLT;
            default: op = OP_ADD;
        endcase
        return op;
    endfunction

    // Operations that need the subtracting adder.
    function automatic logic op_uses_sub(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

endpackage

// File: rtl/alu_func_decode.sv
module alu_func_decode
    import alu_pkg::*;
(
    input  logic [1:0]        op_class_i,
    input  logic [FUNC_W-1:0] func_i,
    output alu_op_e           op_o
);

    op_class_e cls;

    always_comb begin
        cls = op_class_e'(op_class_i);
        case (cls)
            CLS_ADD:  op_o = OP_ADD;
            CLS_SUB:  op_o = OP_SUB;
            CLS_FUNC: op_o = func_to_op(func_i);
            default:  op_o = OP_ADD;
        endcase
    end

    always_comb begin
        if (op_class_i == 2'b00) begin
            p_class_add_r1: assert (op_o == OP_ADD)
                else $error("class 00 did not select add");
        end
        if (op_class_i == 2'b01) begin
            p_class_sub_r2: assert (op_o == OP_SUB)
                else $error("class 01 did not select subtract");
        end
        if (op_class_i == 2'b11) begin
            p_class_rsvd_r4: assert (op_o == OP_ADD)
                else $error("class 11 did not select add");
        end
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             less_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] cin_vec;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        cin_vec = {{(WIDTH-1){1'b0}}, sub_i};
        sum_o   = a_i + b_eff + cin_vec;
        // Signed compare: differing signs decide directly, else the difference sign.
        if (a_i[MSB] != b_i[MSB]) less_o = a_i[MSB];
        else                      less_o = sum_o[MSB];
    end

    always_comb begin
        if (sub_i && (a_i == b_i)) begin
            p_equal_diff_r5: assert (sum_o == '0)
                else $error("equal operands gave non-zero difference");
        end
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] y_o
);

    logic pick_and;
    logic pick_nor;

    assign pick_and = (op_i == OP_AND);
    assign pick_nor = (op_i == OP_NOR);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic and_b;
        logic or_b;
        assign and_b  = a_i[i] & b_i[i];
        assign or_b   = a_i[i] | b_i[i];
        assign y_o[i] = pick_and ? and_b : (pick_nor ? ~or_b : or_b);
    end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic [1:0]        op_class_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic [WIDTH-1:0]  result_o,
    output logic              zero_o,
    output logic [3:0]        op_sel_o
);

    alu_op_e          op;
    logic             do_sub;
    logic [WIDTH-1:0] arith_y;
    logic             less;
    logic [WIDTH-1:0] logic_y;

    alu_func_decode u_decode (
        .op_class_i (op_class_i),
        .func_i     (func_i),
        .op_o       (op)
    );

    assign do_sub = op_uses_sub(op);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (do_sub),
        .sum_o  (arith_y),
        .less_o (less)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i  (a_i),
        .b_i  (b_i),
        .op_i (op),
        .y_o  (logic_y)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB: result_o = arith_y;
            OP_SLT:         result_o = {{(WIDTH-1){1'b0}}, less};
            default:        result_o = logic_y;
        endcase
    end

    assign zero_o   = ~|result_o;
    assign op_sel_o = op;

    always_comb begin
        if (op == OP_SLT) begin
            p_slt_upper_clear_r6: assert (result_o[WIDTH-1:1] == '0)
                else $error("set-less-than upper bits not clear");
        end
        if ((op == OP_SUB) && (a_i == b_i)) begin
            p_sub_equal_zero_r7: assert (zero_o)
                else $error("zero flag low for equal operands");
        end
    end

endmodule

// File: tb/alu_unit_tb.sv
`timescale 1ns/1ps
module alu_unit_tb;

    localparam int W = 32;
    localparam int NV = 18;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic [1:0]   cls;
    logic [5:0]   fn;
    logic [W-1:0] result;
    logic         zero;
    logic [3:0]   sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    alu_unit #(.WIDTH(W)) u_dut (
        .a_i(a), .b_i(b), .op_class_i(cls), .func_i(fn),
        .result_o(result), .zero_o(zero), .op_sel_o(sel)
    );

    // {class[107:106], func[105:100], a[99:68], b[67:36], sel[35:32], result[31:0]}
    localparam logic [107:0] VEC [NV] = '{
        {2'b00, 6'h3F, 32'd5,          32'd7,          4'b0010, 32'd12},          // R1
        {2'b01, 6'h20, 32'd10,         32'd3,          4'b0110, 32'd7},           // R2
        {2'b10, 6'h20, 32'h0000_00F0, 32'h0000_000F, 4'b0010, 32'h0000_00FF},    // R3 add
        {2'b10, 6'h22, 32'h10,         32'h3,          4'b0110, 32'hD},           // R3 sub
        {2'b10, 6'h24, 32'hFF00_FF00, 32'h0FF0_0FF0, 4'b0000, 32'h0F00_0F00},    // R8 and
        {2'b10, 6'h25, 32'hFF00_FF00, 32'h0FF0_0FF0, 4'b0001, 32'hFFF0_FFF0},    // R8 or
        {2'b10, 6'h27, 32'hFF00_FF00, 32'h0FF0_0FF0, 4'b1100, 32'h000F_000F},    // R8 nor
        {2'b10, 6'h2A, 32'hFFFF_FFFF, 32'd1,          4'b0111, 32'd1},           // R6
        {2'b10, 6'h2A, 32'd1,          32'hFFFF_FFFF, 4'b0111, 32'd0},           // R6
        {2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, 4'b0111, 32'd1},           // R6
        {2'b11, 6'h22, 32'd2,          32'd3,          4'b0010, 32'd5},           // R4
        {2'b10, 6'h3F, 32'd2,          32'd3,          4'b0010, 32'd5},           // R4
        {2'b00, 6'h00, 32'hFFFF_FFFF, 32'd1,          4'b0010, 32'd0},           // R5
        {2'b01, 6'h00, 32'd0,          32'd1,          4'b0110, 32'hFFFF_FFFF},   // R5
        {2'b01, 6'h2A, 32'h1234,       32'h1234,       4'b0110, 32'd0},           // R7
        {2'b10, 6'h2A, 32'd5,          32'd5,          4'b0111, 32'd0},           // R7
        {2'b10, 6'h24, 32'hAAAA_AAAA, 32'h5555_5555, 4'b0000, 32'd0},           // R7
        {2'b00, 6'h27, 32'h7FFF_FFFF, 32'd1,          4'b0010, 32'h8000_0000}    // R5
    };
    localparam int VREQ [NV] = '{1, 2, 3, 3, 8, 8, 8, 6, 6, 6, 4, 4, 5, 5, 7, 7, 7, 5};

    task automatic check(input string req, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Select expected from the requirement text (R1..R4).
    function automatic logic [3:0] model_sel(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b01) return 4'b0110;
        if (c != 2'b10) return 4'b0010;
        case (f)
            6'b100010: return 4'b0110;
            6'b100100: return 4'b0000;
            6'b100101: return 4'b0001;
            6'b100111: return 4'b1100;
            6'b101010: return 4'b0111;
            default:   return 4'b0010;
        endcase
    endfunction

    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [W-1:0] va, input logic [W-1:0] vb);
        @(negedge clk);
        cls = c; fn = f; a = va; b = vb;
        #1;
    endtask

    initial begin
        cls = 2'b00; fn = 6'h00; a = '0; b = '0;
        // Quiet state: class 00 on zero operands
        @(negedge clk); #1;
        check("R1", "initial sel", {28'd0, sel}, 32'h2);
        check("R7", "initial zero", {31'd0, zero}, 32'd1);
        check("R1", "initial result", result, 32'd0);

        for (int i = 0; i < NV; i++) begin
            string r;
            logic [107:0] v;
            v = VEC[i];
            r = $sformatf("R%0d", VREQ[i]);
            apply(v[107:106], v[105:100], v[99:68], v[67:36]);
            check(r, $sformatf("vec %0d sel", i), {28'd0, sel}, {28'd0, v[35:32]});
            check(r, $sformatf("vec %0d result", i), result, v[31:0]);
            check("R7", $sformatf("vec %0d zero", i), {31'd0, zero},
                  {31'd0, (v[31:0] == '0)});
        end

        // R3 / R4: every function code under every class
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                apply(c[1:0], f[5:0], 32'd9, 32'd4);
                check((c == 2) ? "R3" : "R4", $sformatf("sweep c=%0d f=%0d sel", c, f),
                      {28'd0, sel}, {28'd0, model_sel(c[1:0], f[5:0])});
            end
        end

        // R6: signed compare over walking sign patterns
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] va, vb;
            va = 32'h1 << k;
            vb = ~va;
            apply(2'b10, 6'h2A, va, vb);
            check("R6", $sformatf("slt walk %0d", k), result,
                  {31'd0, ($signed(va) < $signed(vb))});
        end

        // R8: NOR with all ones gives zero and raises zero flag
        apply(2'b10, 6'h27, 32'hFFFF_FFFF, 32'd0);
        check("R8", "nor all ones", result, 32'd0);
        check("R7", "nor zero flag", {31'd0, zero}, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule